// File: doc/BRIEF.md
# NAND Read-Retry Register Programmer

This block switches a NAND flash device into one of several read-retry modes. It does this by writing a group of vendor-private parameter registers inside the device. Each register write and each control command goes out as one operation on a simple operation bus. An operation is a command byte, an address byte or a data-out byte, and it is held under a valid/ready handshake until the bus accepts it.

The block keeps a value table of `NMODES * NREGS` bytes. A host or an extraction engine loads it through a byte write port. The register address list is fixed, and it is also the order in which the registers are programmed. A one-cycle start request carries a mode number. The block then sends a parameter-entry command, one address/data pair per register, and an apply command. After that it pulses done, with fail showing whether the run was aborted or rejected.

Top module: `nand_rr_prog`

## Requirements
- R1: After synchronous reset, `op_valid`, `busy`, `done` and `fail` are all low.
- R2: An accepted start leads to a first operation on the bus in the next cycle. That operation is a command (`op_kind` = 0) with byte 0x36.
- R3: After the entry command, the block sends one pair of operations per register index i = 0..NREGS-1. The pair is an address operation (`op_kind` = 1) carrying the i-th entry of the list 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE, 0xAF, then a data operation (`op_kind` = 2) carrying table byte `mode*NREGS + i`.
- R4: The last operation is a command (`op_kind` = 0) with byte 0x16. In the cycle after it is accepted, `done` is high for exactly one cycle with `fail` low.
- R5: While `op_valid` is high and `op_ready` is low, the operation kind and byte stay unchanged. Exactly one operation completes per cycle in which both are high.
- R6: If `op_err` is high in an accepting cycle, the block sends no further operation. In the next cycle, `done` and `fail` are both high.
- R7: A start with `mode >= NMODES` produces no operation. In the next cycle, `done` and `fail` are both high.
- R8: A start raised while `busy` is high is ignored, and the running sequence continues unchanged.
- R9: A cycle with `tbl_we` high stores `tbl_wdata` at table index `tbl_waddr`. Later sequences use the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Value table write strobe |
| tbl_waddr | input | TBL_AW | Value table write index (mode*NREGS + register) |
| tbl_wdata | input | 8 | Value table write byte |
| start | input | 1 | One-cycle request to program a mode |
| mode | input | MODE_W | Requested read-retry mode |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fail | output | 1 | High with done when the run aborted or was rejected |
| op_valid | output | 1 | Operation offered on the bus |
| op_kind | output | 2 | 0 command, 1 address, 2 data-out |
| op_byte | output | 8 | Operation byte |
| op_ready | input | 1 | Bus accepts the offered operation |
| op_err | input | 1 | Bus reports the accepted operation failed |

## Verification
A wrong register index or wrong latched mode does not stay hidden. It shows up at the very next address or data operation as a wrong byte, so the fault is visible within one handshake. A state machine that skips or repeats a step shows up as an operation count other than 2*NREGS+2, or as a done pulse that arrives early or late. A bad abort path shows up as bus activity continuing after an error in the cycle that follows it. Every mode is swept with different ready stall lengths, and an error is injected at every position in the sequence, so each of these faults surfaces at a known operation.

// File: rtl/nand_rr_pkg.sv
package nand_rr_pkg;

    typedef enum logic [1:0] {
        OP_CMD  = 2'd0,
        OP_ADDR = 2'd1,
        OP_DATA = 2'd2
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ENTER,
        S_ADDR,
        S_DATA,
        S_APPLY
    } seq_state_e;

    typedef struct packed {
        op_kind_e    kind;
        logic [7:0]  payload;
    } bus_op_t;

    localparam logic [7:0] CMD_ENTER_PARAMS = 8'h36;
    localparam logic [7:0] CMD_APPLY_PARAMS = 8'h16;

    // Register address for programming slot idx (order is the write order).
    function automatic logic [7:0] rr_reg_addr(input logic [7:0] idx);
        logic [7:0] a;
        case (idx)
            8'd0:    a = 8'hCC;
            8'd1:    a = 8'hBF;
            8'd2:    a = 8'hAA;
            8'd3:    a = 8'hAB;
            8'd4:    a = 8'hCD;
            8'd5:    a = 8'hAD;
            8'd6:    a = 8'hAE;
            8'd7:    a = 8'hAF;
            default: a = 8'h00;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/rr_value_tbl.sv
module rr_value_tbl #(
    parameter int DEPTH = 48,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && (int'(waddr) < DEPTH)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
endmodule

// File: rtl/rr_seq.sv
module rr_seq
    import nand_rr_pkg::*;
#(
    parameter int NREGS  = 8,
    parameter int NMODES = 6,
    localparam int MODE_W = (NMODES > 1) ? $clog2(NMODES) : 1,
    localparam int IDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
    localparam int TBL_AW = $clog2(NREGS * NMODES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              op_valid,
    output bus_op_t           op,
    input  logic              op_ready,
    input  logic              op_err,
    output logic [TBL_AW-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    localparam logic [MODE_W:0]  MODE_LIM = (MODE_W+1)'(NMODES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREGS - 1);

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [MODE_W-1:0] mode_q;
    logic              done_q, fail_q;
    logic              bad_mode;

    assign bad_mode = ({1'b0, mode} >= MODE_LIM);
    assign rd_addr  = TBL_AW'(int'(mode_q) * NREGS) + TBL_AW'(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            idx    <= '0;
            mode_q <= '0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            if (state == S_IDLE) begin
                if (start) begin
                    if (bad_mode) begin
                        done_q <= 1'b1;
                        fail_q <= 1'b1;
                    end else begin
                        mode_q <= mode;
                        idx    <= '0;
                        state  <= S_ENTER;
                    end
                end
            end else if (op_ready) begin
                if (op_err) begin
                    done_q <= 1'b1;
                    fail_q <= 1'b1;
                    state  <= S_IDLE;
                end else begin
                    case (state)
                        S_ENTER: state <= S_ADDR;
                        S_ADDR:  state <= S_DATA;
                        S_DATA: begin
                            if (idx == LAST_IDX) begin
                                state <= S_APPLY;
                            end else begin
                                idx   <= idx + 1'b1;
                                state <= S_ADDR;
                            end
                        end
                        S_APPLY: begin
                            done_q <= 1'b1;
                            state  <= S_IDLE;
                        end
                        default: state <= S_IDLE;
                    endcase
                end
            end
        end
    end

    always_comb begin
        op_valid = (state != S_IDLE);
        case (state)
            S_ENTER: op = '{kind: OP_CMD,  payload: CMD_ENTER_PARAMS};
            S_ADDR:  op = '{kind: OP_ADDR, payload: rr_reg_addr(8'(idx))};
            S_DATA:  op = '{kind: OP_DATA, payload: rd_data};
            S_APPLY: op = '{kind: OP_CMD,  payload: CMD_APPLY_PARAMS};
            default: op = '{kind: OP_CMD,  payload: 8'h00};
        endcase
    end

    assign busy = (state != S_IDLE);
    assign done = done_q;
    assign fail = fail_q;

    AST_FIRST_ENTER: assert property (@(posedge clk) disable iff (rst)
        $rose(op_valid) |-> (op.kind == OP_CMD && op.payload == CMD_ENTER_PARAMS)); // R2
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4
    AST_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_ready) |=> (op_valid && $stable(op))); // R5
    AST_ABORT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_err) |=> (done && fail && !op_valid)); // R6
    AST_BAD_MODE: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && bad_mode) |=> (done && fail && !op_valid)); // R7
    AST_FAIL_DONE: assert property (@(posedge clk) disable iff (rst)
        fail |-> done); // R6
endmodule

// File: rtl/nand_rr_prog.sv
module nand_rr_prog
    import nand_rr_pkg::*;
#(
    parameter int NREGS  = 8,
    parameter int NMODES = 6,
    localparam int MODE_W = (NMODES > 1) ? $clog2(NMODES) : 1,
    localparam int TBL_AW = $clog2(NREGS * NMODES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [TBL_AW-1:0] tbl_waddr,
    input  logic [7:0]        tbl_wdata,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              op_valid,
    output logic [1:0]        op_kind,
    output logic [7:0]        op_byte,
    input  logic              op_ready,
    input  logic              op_err
);
    bus_op_t           op;
    logic [TBL_AW-1:0] rd_addr;
    logic [7:0]        rd_data;

    rr_value_tbl #(.DEPTH(NREGS * NMODES)) u_tbl (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    rr_seq #(.NREGS(NREGS), .NMODES(NMODES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode     (mode),
        .busy     (busy),
        .done     (done),
        .fail     (fail),
        .op_valid (op_valid),
        .op       (op),
        .op_ready (op_ready),
        .op_err   (op_err),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    assign op_kind = op.kind;
    assign op_byte = op.payload;
endmodule

// File: tb/nand_rr_prog_bench.sv
module nand_rr_prog_bench;
    localparam int NR = 8;
    localparam int NM = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tbl_we = 1'b0;
    logic [5:0] tbl_waddr = '0;
    logic [7:0] tbl_wdata = '0;
    logic       start = 1'b0;
    logic [2:0] mode = '0;
    logic       busy, done, fail, op_valid;
    logic [1:0] op_kind;
    logic [7:0] op_byte;
    logic       op_ready = 1'b0;
    logic       op_err = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_tbl [NR*NM];
    logic [7:0] addr_list [NR];

    always #10 clk = ~clk;

    nand_rr_prog u_nand_rr_prog (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .start(start), .mode(mode), .busy(busy),
        .done(done), .fail(fail), .op_valid(op_valid), .op_kind(op_kind),
        .op_byte(op_byte), .op_ready(op_ready), .op_err(op_err)
    );

    task automatic chk(input string req, input bit ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tbl_write(input int idx, input logic [7:0] v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = 6'(idx); tbl_wdata = v;
        exp_tbl[idx] = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Expected kind/byte of operation n for mode m.
    task automatic exp_op(input int m, input int n, output int k, output int b);
        if (n == 0) begin k = 0; b = 'h36; end
        else if (n == 2*NR + 1) begin k = 0; b = 'h16; end
        else if (n % 2 == 1) begin k = 1; b = addr_list[(n-1)/2]; end
        else begin k = 2; b = exp_tbl[m*NR + (n-1)/2]; end
    endtask

    task automatic run(input int m, input int err_at, input int dly, input bit poke);
        int n = 0;
        int stall = 0;
        bit seen_done = 0;
        bit got_fail = 0;
        bit have_prev = 0;
        logic [1:0] pk = '0;
        logic [7:0] pb = '0;
        int ek, eb, exp_n;
        bit bad = (m >= NM);
        @(negedge clk);
        start = 1'b1; mode = 3'(m);
        for (int cyc = 0; cyc < 200 && !seen_done; cyc++) begin
            @(negedge clk);
            op_ready = 1'b0; op_err = 1'b0; start = 1'b0;
            if (done) begin
                seen_done = 1; got_fail = fail;
                chk("R6/R7 no op with done", !op_valid, op_valid, 0);
            end else if (op_valid) begin
                if (have_prev)
                    chk("R5 hold while stalled", op_kind == pk && op_byte == pb,
                        {op_kind, op_byte}, {pk, pb});
                if (stall < dly) begin
                    stall++; have_prev = 1; pk = op_kind; pb = op_byte;
                    if (poke && n == 3) begin start = 1'b1; mode = 3'((m+1) % NM); end
                end else begin
                    exp_op(m, n, ek, eb);
                    if (n == 0) chk("R2 entry command", op_kind == 2'(ek) && op_byte == 8'(eb), {op_kind, op_byte}, (ek<<8)|eb);
                    else if (n == 2*NR+1) chk("R4 apply command", op_kind == 2'(ek) && op_byte == 8'(eb), {op_kind, op_byte}, (ek<<8)|eb);
                    else chk(poke ? "R3/R8 register op" : "R3 register op", op_kind == 2'(ek) && op_byte == 8'(eb), {op_kind, op_byte}, (ek<<8)|eb);
                    op_ready = 1'b1; op_err = (n == err_at);
                    n++; stall = 0; have_prev = 0;
                end
            end
        end
        exp_n = bad ? 0 : (err_at >= 0 ? err_at + 1 : 2*NR + 2);
        chk("R4 done seen", seen_done, seen_done, 1);
        chk(bad ? "R7 fail flag" : (err_at >= 0 ? "R6 fail flag" : "R4 fail flag"),
            got_fail == (bad || err_at >= 0), got_fail, (bad || err_at >= 0));
        chk(bad ? "R7 op count" : "R6 op count", n == exp_n, n, exp_n);
        @(negedge clk);
        chk("R4 done one cycle", !done, done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        addr_list = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset op_valid", !op_valid, op_valid, 0);
        chk("R1 reset busy", !busy, busy, 0);
        chk("R1 reset done/fail", !done && !fail, {done, fail}, 0);
        for (int i = 0; i < NR*NM; i++) tbl_write(i, 8'((i*29 + 7) & 8'hFF));
        for (int m = 0; m < NM; m++) run(m, -1, m % 3, 1'b0);
        run(1, -1, 1, 1'b1);                       // R8
        for (int e = 0; e < 2*NR + 2; e++) run(3, e, e % 2, 1'b0); // R6
        run(6, -1, 0, 1'b0);                        // R7
        run(7, -1, 0, 1'b0);                        // R7
        tbl_write(3, 8'h5A);                        // R9
        tbl_write(NR*NM - 1, 8'hC3);                // R9
        run(0, -1, 2, 1'b0);
        run(NM - 1, -1, 0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule